// File: doc/BRIEF.md
# Asynchronous Serial Port with Receiver Wake-Up

This block transmits and receives asynchronous NRZ serial words. The line idles at mark (high). A frame is one space start bit, then 8 or 9 data bits sent least significant bit first, then one mark stop bit. When parity is on, the parity bit takes the place of the top data bit. Timing comes from a modulus divider on the system clock, and that divider produces a sample tick at sixteen times the bit rate. The transmitter and the receiver each have one holding register in front of their shift register, so software can write the next word, or read the last one, while a frame is on the line.

The receiver samples each bit sixteen times. It decides the bit by a majority vote of samples 7, 8 and 9, and it flags noise when those three samples disagree. It also flags framing, parity and overrun errors. In wake-up mode the receiver drops every frame until one of two events: a full character time of mark on the line (idle-line mode), or a frame whose most significant data bit is 1 (address mode). In address mode, the frame that wakes the receiver is itself delivered.

Software reaches the block through four word-wide registers, selected by `addr`: 0 control, 1 status, 2 divisor, 3 data.

Top module: `sci_wake`

## Requirements
- R1: After reset, `txd` is high. Status reads 0x03: bit 0 is transmit holding empty and bit 1 is transmitter idle, and every other status bit is 0. Control and divisor both read 0.
- R2: The sample tick occurs once every 2×divisor clocks, so one bit lasts 32×divisor clocks. A divisor of 0 stops the tick, and with it all transmission.
- R3: A transmitted frame is a space start bit, then the data bits least significant first, then a mark stop bit. Control bit 2 selects 9 data bits when set and 8 when clear.
- R4: With control bit 3 set, the transmitter replaces the top data bit with a parity bit computed over the lower data bits. The parity is even when control bit 4 is clear and odd when it is set.
- R5: Writing the data register fills the transmit holding register, and status bit 0 goes to 0. The word moves to the shifter on a sample tick, after which status bit 0 returns to 1 while the frame is still being sent. Nothing is loaded while the transmit enable, control bit 0, is clear.
- R6: A received word appears in the data register, and status bit 2 (receive full) is set. Reading the data register clears status bits 2 to 6.
- R7: Each bit is the majority of its samples 7, 8 and 9. If those three samples disagree in any bit of the frame, status bit 4 (noise) is set, and the word is still delivered.
- R8: A stop bit that votes as space sets status bit 5 (framing error).
- R9: A word that completes while status bit 2 is set is discarded, and status bit 3 (overrun) is set. The held word is kept.
- R10: With parity enabled, a received word whose bit count (data bits plus parity bit) does not match the selected parity sets status bit 6.
- R11: While control bit 1 (receive enable) is clear, frames on `rxd` are ignored.
- R12: Writing control with bit 5 set puts the receiver to sleep, shown as status bit 7. With control bit 6 clear, frames are dropped until the line has been mark for a full character time (10 or 11 bit times). After that, frames are received normally.
- R13: With control bit 6 set, a sleeping receiver ignores idle time and drops frames whose most significant data bit is 0. The first frame whose most significant data bit is 1 wakes the receiver and is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select: 0 control, 1 status, 2 divisor, 3 data |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe; a read of the data register clears receive status |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the selected register |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
Receive status is due within a few clocks of the middle of the stop bit. That delay is the input synchronizer plus one sample tick. The bench therefore reads status only after it has driven the whole stop bit and then waited eight more clocks. The transmitter starts its start bit within one sample tick of the write, so the bench first waits for the falling edge of `txd`. It then samples each bit 16 clocks past that edge plus a whole number of bit periods, which places every sample in the middle of a bit. Idle-line wake-up is due 10 bit times after the last stop bit. The bench checks that the receiver is still asleep shortly after a frame, and that it is awake after 400 clocks.

// File: rtl/sci_pkg.sv
package sci_pkg;
   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_STAT = 2'd1;
   localparam logic [1:0] A_DIV  = 2'd2;
   localparam logic [1:0] A_DATA = 2'd3;

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

   // bit 0 is tx_on ... bit 6 is wake_by_addr
   typedef struct packed {
      logic wake_by_addr;
      logic sleep_req;
      logic par_odd;
      logic par_on;
      logic nine;
      logic rx_on;
      logic tx_on;
   } ctrl_t;
endpackage

// File: rtl/sci_baud.sv
module sci_baud #(
   parameter int DIV_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int CNT_W = DIV_W + 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;

   if (DIV_W < 2 || DIV_W > 16) begin : g_bad_div
      $error("sci_baud: DIV_W must lie in 2..16");
   end

   assign lim = {div, 1'b0} - {{(CNT_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (div == '0) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt >= lim) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end

   // R2: ticks are never closer than two clocks
   assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
   // R2: a zero divisor stops the tick
   assert_zero_div_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (div == '0) |=> !tick);
endmodule

// File: rtl/sci_tx.sv
module sci_tx #(
   parameter int OVR = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       en,
   input  logic       nine,
   input  logic       par_on,
   input  logic       par_odd,
   input  logic       wr,
   input  logic [8:0] wdata,
   output logic       txd,
   output logic       hold_empty,
   output logic       idle
);
   localparam int SW = $clog2(OVR);
   localparam logic [SW-1:0] S_LAST = SW'(OVR - 1);

   logic [8:0]    hold;
   logic          hold_full;
   logic          busy;
   logic [SW-1:0] tcnt;
   logic [3:0]    left;
   logic [10:0]   sh;
   logic [8:0]    word;
   logic [10:0]   frame;

   always_comb begin
      word = hold;
      if (!nine) word[8] = 1'b0;
      if (par_on) begin
         if (nine) word[8] = (^hold[7:0]) ^ par_odd;
         else      word[7] = (^hold[6:0]) ^ par_odd;
      end
      frame = nine ? {1'b1, word, 1'b0} : {2'b11, word[7:0], 1'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold      <= '0;
         hold_full <= 1'b0;
         busy      <= 1'b0;
         tcnt      <= '0;
         left      <= '0;
         sh        <= '1;
      end else begin
         if (tick) begin
            if (!busy) begin
               if (hold_full && en) begin
                  sh        <= frame;
                  busy      <= 1'b1;
                  tcnt      <= '0;
                  left      <= nine ? 4'd11 : 4'd10;
                  hold_full <= 1'b0;
               end
            end else begin
               tcnt <= tcnt + 1'b1;
               if (tcnt == S_LAST) begin
                  sh   <= {1'b1, sh[10:1]};
                  left <= left - 4'd1;
                  if (left == 4'd1) busy <= 1'b0;
               end
            end
         end
         if (wr) begin
            hold      <= wdata;
            hold_full <= 1'b1;
         end
      end
   end

   assign txd        = busy ? sh[0] : 1'b1;
   assign hold_empty = !hold_full;
   assign idle       = !busy && !hold_full;

   // R3: every frame opens with a space start bit
   assert_start_space_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !txd);
   // R5: the shifter only loads from a full holding register
   assert_load_from_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(hold_full));
endmodule

// File: rtl/sci_rx.sv
module sci_rx
   import sci_pkg::*;
#(
   parameter int OVR  = 16,
   parameter int SYNC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       en,
   input  logic       nine,
   input  logic       par_on,
   input  logic       par_odd,
   input  logic       wake_by_addr,
   input  logic       sleep_set,
   input  logic       rd,
   input  logic       rxd,
   output logic [8:0] data,
   output logic       full,
   output logic       ovr,
   output logic       noise_f,
   output logic       frame_f,
   output logic       par_f,
   output logic       asleep
);
   localparam int SW  = $clog2(OVR);
   localparam int MID = OVR / 2;
   localparam int IDW = $clog2(OVR * 11 + 1);
   localparam logic [SW-1:0] S_A   = SW'(MID - 2);
   localparam logic [SW-1:0] S_B   = SW'(MID - 1);
   localparam logic [SW-1:0] S_C   = SW'(MID);
   localparam logic [SW-1:0] S_END = SW'(OVR - 1);

   if (OVR < 8 || (OVR & (OVR - 1)) != 0) begin : g_bad_ovr
      $error("sci_rx: OVR must be a power of two of at least 8");
   end
   if (SYNC < 2) begin : g_bad_sync
      $error("sci_rx: SYNC must be at least 2");
   end

   logic [SYNC-1:0] sy;
   logic            rxs;
   rx_state_t       st;
   logic [SW-1:0]   scnt;
   logic [1:0]      v;
   logic [3:0]      bitn;
   logic [8:0]      rsh;
   logic            fnoise;
   logic [IDW-1:0]  icnt;
   logic [IDW-1:0]  thr;
   logic            maj, nz, perr, accept;
   logic [8:0]      fin;

   always_comb begin
      rxs    = sy[SYNC-1];
      maj    = (v[0] & v[1]) | (v[0] & rxs) | (v[1] & rxs);
      nz     = !((v[0] == v[1]) && (v[1] == rxs));
      fin    = nine ? rsh : {1'b0, rsh[8:1]};
      perr   = par_on && ((^fin) != par_odd);
      accept = (!asleep || (wake_by_addr && rsh[8])) && !sleep_set;
      thr    = nine ? IDW'(OVR * 11) : IDW'(OVR * 10);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sy <= '1;  st <= RX_IDLE;  scnt <= '0;  v <= '0;  bitn <= '0;
         rsh <= '0;  fnoise <= 1'b0;  icnt <= '0;  data <= '0;  full <= 1'b0;
         ovr <= 1'b0;  noise_f <= 1'b0;  frame_f <= 1'b0;  par_f <= 1'b0;
         asleep <= 1'b0;
      end else begin
         sy <= {sy[SYNC-2:0], rxd};
         if (rd) begin
            full <= 1'b0;  ovr <= 1'b0;  noise_f <= 1'b0;
            frame_f <= 1'b0;  par_f <= 1'b0;
         end
         if (tick) begin
            if (!en) begin
               st <= RX_IDLE;
            end else if (st == RX_IDLE) begin
               if (!rxs) begin
                  st     <= RX_START;
                  scnt   <= SW'(1);
                  fnoise <= 1'b0;
               end
            end else begin
               scnt <= scnt + 1'b1;
               if (scnt == S_A) v[0] <= rxs;
               if (scnt == S_B) v[1] <= rxs;
               if (scnt == S_C) begin
                  case (st)
                     RX_START: if (maj) st <= RX_IDLE; else fnoise <= nz;
                     RX_DATA: begin
                        rsh    <= {maj, rsh[8:1]};
                        fnoise <= fnoise | nz;
                     end
                     RX_STOP: begin
                        st <= RX_IDLE;
                        if (accept) begin
                           asleep <= 1'b0;
                           if (full && !rd) begin
                              ovr <= 1'b1;
                           end else begin
                              data    <= fin;
                              full    <= 1'b1;
                              noise_f <= fnoise | nz;
                              frame_f <= !maj;
                              par_f   <= perr;
                           end
                        end
                     end
                     default: ;
                  endcase
               end
               if (scnt == S_END) begin
                  if (st == RX_START) begin
                     st   <= RX_DATA;
                     bitn <= '0;
                  end else if (st == RX_DATA) begin
                     bitn <= bitn + 4'd1;
                     if (bitn == (nine ? 4'd8 : 4'd7)) st <= RX_STOP;
                  end
               end
            end
            if (!rxs || st != RX_IDLE) begin
               icnt <= '0;
            end else if (icnt != thr) begin
               icnt <= icnt + 1'b1;
               if (icnt == thr - IDW'(1) && asleep && !wake_by_addr) asleep <= 1'b0;
            end
         end
         if (sleep_set) begin
            asleep <= 1'b1;
            icnt   <= '0;
         end
      end
   end

   // R13: a word is never delivered while the receiver sleeps
   assert_no_data_asleep_R13: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full) |-> !asleep);
   // R9: overrun only arises over a held word
   assert_overrun_needs_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $past(full));
   // R7: the noise flag always belongs to a held word
   assert_noise_with_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(noise_f) |-> full);
endmodule

// File: rtl/sci_wake.sv
module sci_wake
   import sci_pkg::*;
#(
   parameter int DIV_W = 13,
   parameter int OVR   = 16,
   parameter int SYNC  = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  addr,
   input  logic        wr_en,
   input  logic        rd_en,
   input  logic [15:0] wdata,
   output logic [15:0] rdata,
   input  logic        rxd,
   output logic        txd
);
   ctrl_t            ctrl;
   logic [DIV_W-1:0] div;
   logic             tick;
   logic             tx_empty, tx_idle;
   logic [8:0]       rx_data;
   logic             rx_full, rx_ovr, rx_noise, rx_frame, rx_par, rx_asleep;
   logic             wr_data, rd_data, sleep_set;
   logic             unused_wbits;

   assign wr_data      = wr_en && (addr == A_DATA);
   assign rd_data      = rd_en && (addr == A_DATA);
   assign sleep_set    = wr_en && (addr == A_CTRL) && wdata[5];
   assign unused_wbits = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
         div  <= '0;
      end else if (wr_en) begin
         if (addr == A_CTRL) ctrl <= ctrl_t'(wdata[6:0]);
         if (addr == A_DIV)  div  <= wdata[DIV_W-1:0];
      end
   end

   always_comb begin
      case (addr)
         A_CTRL:  rdata = {9'b0, ctrl};
         A_STAT:  rdata = {8'b0, rx_asleep, rx_par, rx_frame, rx_noise,
                           rx_ovr, rx_full, tx_idle, tx_empty};
         A_DIV:   rdata = {{(16-DIV_W){1'b0}}, div};
         default: rdata = {7'b0, rx_data};
      endcase
   end

   sci_baud #(.DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .div(div), .tick(tick));

   sci_tx #(.OVR(OVR)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(ctrl.tx_on), .nine(ctrl.nine),
      .par_on(ctrl.par_on), .par_odd(ctrl.par_odd), .wr(wr_data),
      .wdata(wdata[8:0]), .txd(txd), .hold_empty(tx_empty), .idle(tx_idle));

   sci_rx #(.OVR(OVR), .SYNC(SYNC)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(ctrl.rx_on), .nine(ctrl.nine),
      .par_on(ctrl.par_on), .par_odd(ctrl.par_odd), .wake_by_addr(ctrl.wake_by_addr),
      .sleep_set(sleep_set), .rd(rd_data), .rxd(rxd), .data(rx_data),
      .full(rx_full), .ovr(rx_ovr), .noise_f(rx_noise), .frame_f(rx_frame),
      .par_f(rx_par), .asleep(rx_asleep));

   // R1: the line rests at mark whenever the transmitter is idle
   assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_idle |-> txd);
endmodule

// File: tb/sci_wake_bench.sv
module sci_wake_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        rxd_drv = 1'b1;
   logic        loop = 1'b0;
   logic        rxd, txd;
   int          n_chk = 0;
   int          n_fail = 0;

   always #10 clk = ~clk;
   assign rxd = loop ? txd : rxd_drv;

   sci_wake u_sci_wake (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd));

   // {nine, par_on, par_odd, raw frame bits[8:0], expected word[8:0], expected parity flag}
   localparam logic [21:0] RXV [0:6] = '{
      {1'b0, 1'b0, 1'b0, 9'h0A5, 9'h0A5, 1'b0},
      {1'b1, 1'b0, 1'b0, 9'h15A, 9'h15A, 1'b0},
      {1'b0, 1'b1, 1'b0, 9'h003, 9'h003, 1'b0},
      {1'b0, 1'b1, 1'b0, 9'h007, 9'h007, 1'b1},
      {1'b1, 1'b1, 1'b1, 9'h101, 9'h101, 1'b1},
      {1'b1, 1'b1, 1'b1, 9'h001, 9'h001, 1'b0},
      {1'b0, 1'b0, 1'b0, 9'h1FF, 9'h0FF, 1'b0}
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic drive_bit(input logic val, input bit glitch, input int len);
      for (int c = 0; c < len; c++) begin
         rxd_drv = (glitch && (c == 16 || c == 17)) ? ~val : val;
         @(negedge clk);
      end
   endtask

   // 32 clocks per bit at divisor 1; glitch_at < 0 means a clean frame
   task automatic send(input logic [8:0] raw, input int nb, input bit stop_ok, input int glitch_at);
      @(negedge clk);
      drive_bit(1'b0, 1'b0, 32);
      for (int i = 0; i < nb; i++) drive_bit(raw[i], i == glitch_at, 32);
      if (stop_ok) drive_bit(1'b1, 1'b0, 32);
      else begin
         drive_bit(1'b0, 1'b0, 24);
         drive_bit(1'b1, 1'b0, 32);
      end
      rxd_drv = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic wait_fall(input int limit, output bit seen);
      seen = 1'b0;
      for (int i = 0; i < limit && !seen; i++) begin
         @(negedge clk);
         if (!txd) seen = 1'b1;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] d;
      bit seen;
      int len;
      logic [10:0] fr;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 txd idle", int'(txd), 1);
      rd(2'd1, d); chk("R1 status", int'(d), 'h03);
      rd(2'd0, d); chk("R1 control", int'(d), 0);
      rd(2'd2, d); chk("R1 divisor", int'(d), 0);

      wr(2'd2, 16'd1);

      // R6 / R10 receive table
      foreach (RXV[k]) begin
         wr(2'd0, 16'h0003 | (16'(RXV[k][21]) << 2) | (16'(RXV[k][20]) << 3) | (16'(RXV[k][19]) << 4));
         send(RXV[k][18:10], RXV[k][21] ? 9 : 8, 1'b1, -1);
         rd(2'd1, d); chk("R6 R10 rx status", int'(d), RXV[k][0] ? 'h47 : 'h07);
         rd(2'd3, d); chk("R6 rx word", int'(d), int'(RXV[k][9:1]));
         rd(2'd1, d); chk("R6 status after read", int'(d), 'h03);
      end

      // R3 / R5 transmit format and holding register
      wr(2'd0, 16'h0003);
      wr(2'd3, 16'h0035);
      wait_fall(100, seen); chk("R3 start seen", int'(seen), 1);
      rd(2'd1, d); chk("R5 holding empty while sending", int'(d) & 3, 'h1);
      wr(2'd3, 16'h005C);
      rd(2'd1, d); chk("R5 holding full after write", int'(d) & 3, 'h0);
      fr = {2'b11, 8'h35, 1'b0};
      repeat (16 - 6) @(negedge clk);
      for (int b = 0; b < 10; b++) begin
         chk("R3 tx bit first frame", int'(txd), int'(fr[b]));
         if (b < 9) repeat (32) @(negedge clk);
      end
      wait_fall(40, seen); chk("R5 second frame follows", int'(seen), 1);
      fr = {2'b11, 8'h5C, 1'b0};
      repeat (16) @(negedge clk);
      for (int b = 0; b < 10; b++) begin
         chk("R3 tx bit second frame", int'(txd), int'(fr[b]));
         if (b < 9) repeat (32) @(negedge clk);
      end
      repeat (40) @(negedge clk);

      // R4 parity generation through loopback
      loop = 1'b1;
      wr(2'd0, 16'h001F);
      wr(2'd3, 16'h00F3);
      repeat (450) @(negedge clk);
      rd(2'd1, d); chk("R4 odd 9-bit status", int'(d), 'h07);
      rd(2'd3, d); chk("R4 odd 9-bit word", int'(d), 'h1F3);
      wr(2'd0, 16'h000B);
      wr(2'd3, 16'h0013);
      repeat (450) @(negedge clk);
      rd(2'd1, d); chk("R4 even 8-bit status", int'(d), 'h07);
      rd(2'd3, d); chk("R4 even 8-bit word", int'(d), 'h93);
      loop = 1'b0;

      // R7 noise
      wr(2'd0, 16'h0003);
      send(9'h055, 8, 1'b1, 2);
      rd(2'd1, d); chk("R7 noise status", int'(d), 'h17);
      rd(2'd3, d); chk("R7 word by majority", int'(d), 'h55);

      // R8 framing
      send(9'h03C, 8, 1'b0, -1);
      rd(2'd1, d); chk("R8 framing status", int'(d), 'h27);
      rd(2'd3, d); chk("R8 word", int'(d), 'h3C);

      // R9 overrun
      send(9'h011, 8, 1'b1, -1);
      send(9'h022, 8, 1'b1, -1);
      rd(2'd1, d); chk("R9 overrun status", int'(d), 'h0F);
      rd(2'd3, d); chk("R9 first word kept", int'(d), 'h11);

      // R11 receive disabled
      wr(2'd0, 16'h0001);
      send(9'h077, 8, 1'b1, -1);
      rd(2'd1, d); chk("R11 ignored frame", int'(d), 'h03);

      // R12 idle-line wake-up
      wr(2'd0, 16'h0023);
      rd(2'd1, d); chk("R12 asleep", int'(d), 'h83);
      send(9'h044, 8, 1'b1, -1);
      rd(2'd1, d); chk("R12 frame dropped", int'(d), 'h83);
      repeat (400) @(negedge clk);
      rd(2'd1, d); chk("R12 woken by idle", int'(d), 'h03);
      send(9'h066, 8, 1'b1, -1);
      rd(2'd1, d); chk("R12 frame after wake", int'(d), 'h07);
      rd(2'd3, d); chk("R12 word", int'(d), 'h66);

      // R13 address-mark wake-up
      wr(2'd0, 16'h0063);
      send(9'h012, 8, 1'b1, -1);
      rd(2'd1, d); chk("R13 data frame dropped", int'(d), 'h83);
      repeat (400) @(negedge clk);
      rd(2'd1, d); chk("R13 idle ignored", int'(d), 'h83);
      send(9'h092, 8, 1'b1, -1);
      rd(2'd1, d); chk("R13 address frame delivered", int'(d), 'h07);
      rd(2'd3, d); chk("R13 address word", int'(d), 'h92);

      // R2 zero divisor halts, then bit time at divisor 2
      wr(2'd2, 16'd0);
      wr(2'd0, 16'h0001);
      wr(2'd3, 16'h0055);
      repeat (300) @(negedge clk);
      chk("R2 no tx at divisor 0", int'(txd), 1);
      rd(2'd1, d); chk("R2 word still held", int'(d) & 3, 0);
      wr(2'd2, 16'd2);
      wait_fall(100, seen); chk("R2 tx resumes", int'(seen), 1);
      len = 1;
      for (int i = 0; i < 200 && !txd; i++) begin
         @(negedge clk);
         if (!txd) len++;
      end
      chk("R2 bit length 64 clocks", int'(len >= 63 && len <= 65), 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule